// File: doc/BRIEF.md
# Nine-Bit Address-Filtering Serial Receiver

This block receives asynchronous serial frames that carry nine data bits and decides, frame by frame, whether the received word is handed to the host. It is used on a shared multidrop line. Each node normally listens with address filtering on, so it only wakes for words whose ninth bit marks them as addresses. Once a node recognises its own address, host software clears the filter input and the node then receives every following word until it sets the filter again.

The line is oversampled with a clock enable that pulses sixteen times per bit period. The input is synchronised and a start edge is detected. The start bit is confirmed at its middle, and each later bit is sampled once at its centre and shifted into a nine-bit register. At the stop bit the filter input and the ninth bit together decide whether the word moves into a single-entry holding register. That register has a full flag, a framing-error flag, an overrun flag and a read strobe.

Top module: `rx9_addr_rx`

## Requirements
- R1: After reset, rxData is 0, rxBit8 is 0, and rxFull, frameErr and overrun are all low.
- R2: A frame is a low start bit, then nine data bits sent least significant first, then a stop bit. Each bit lasts 16 sampleEn pulses. Received bits 0 to 7 appear on rxData[7:0], and the ninth bit appears on rxBit8.
- R3: While addrDetectEn is 1, a frame whose ninth bit is 0 is discarded. rxData, rxBit8, rxFull, frameErr and overrun keep their values.
- R4: While addrDetectEn is 1, a frame whose ninth bit is 1 is loaded into the holding register and sets rxFull.
- R5: While addrDetectEn is 0, every frame is loaded into the holding register, whatever its ninth bit is.
- R6: A one-cycle pulse on rdStrobe clears rxFull and overrun.
- R7: A low level on the line that has returned high before the middle of the start bit (8 sampleEn pulses after the falling edge) is ignored, and no word is received.
- R8: When a stop bit is sampled low, frameErr is set together with the loaded word, and is cleared by the next loaded word whose stop bit is high. A discarded frame leaves frameErr unchanged.
- R9: If a frame qualifies for loading while rxFull is already set, overrun is set and the held word is kept.
- R10: addrDetectEn is examined only when the stop bit is sampled. A change made partway through a frame applies to that frame's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleEn | input | 1 | Oversampling enable, 16 pulses per bit |
| rxIn | input | 1 | Serial line, idle high |
| addrDetectEn | input | 1 | 1 = accept only words whose ninth bit is 1 |
| rdStrobe | input | 1 | Host read pulse, clears full and overrun |
| rxData | output | 8 | Held word, bits 0 to 7 |
| rxBit8 | output | 1 | Held word, ninth bit |
| rxFull | output | 1 | Holding register contains an unread word |
| frameErr | output | 1 | Held word's stop bit was low |
| overrun | output | 1 | A qualifying word arrived while the register was full |

## Verification
Random frames mix all four combinations of filter setting and ninth bit, so a wrong accept/discard decision shows up as a data or flag mismatch. Random reads between frames separate correct loading from overrun retention. Frames with a bad stop bit, some with the filter on, show whether a discarded frame leaves the error flag alone. Directed cases cover a short glitch that must be rejected as a false start, and a filter change partway through a frame, which shows that the enable is sampled at the stop bit rather than at the start.

// File: rtl/rx9_pkg.sv
package rx9_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rxState_t;

  typedef struct packed {
    logic shiftEn;   // sample current line level into the shift register
    logic frameDone; // stop-bit sample instant: decide on transfer
  } rxStrobe_t;
endpackage

// File: rtl/rx9_ctrl.sv
module rx9_ctrl
  import rx9_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int NBITS = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleEn,
  input  logic      rxS,
  output rxStrobe_t strobes
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(NBITS + 1);
  localparam int HALF = OVS / 2;

  rxState_t       state;
  logic [CW-1:0]  tickCnt;
  logic [BW-1:0]  bitIdx;
  logic           rxLast;
  logic           atEnd;

  assign atEnd = (tickCnt == CW'(OVS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
      rxLast  <= 1'b1;
    end else if (sampleEn) begin
      rxLast <= rxS;
      unique case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          if (rxLast && !rxS) state <= ST_START;
        end
        ST_START: begin
          if (tickCnt == CW'(HALF - 1)) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= rxS ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (atEnd) begin
            tickCnt <= '0;
            if (bitIdx == BW'(NBITS - 1)) state <= ST_STOP;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (atEnd) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.shiftEn   = sampleEn && (state == ST_DATA) && atEnd;
    strobes.frameDone = sampleEn && (state == ST_STOP) && atEnd;
  end
endmodule

// File: rtl/rx9_datapath.sv
module rx9_datapath
  import rx9_pkg::*;
#(
  parameter int NBITS = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  logic             addrDetectEn,
  input  logic             rdStrobe,
  input  rxStrobe_t        strobes,
  output logic             rxS,
  output logic             frameBit8,
  output logic [NBITS-2:0] rxData,
  output logic             rxBit8,
  output logic             rxFull,
  output logic             frameErr,
  output logic             overrun
);
  localparam int DW = NBITS - 1;

  logic [1:0]       syncQ;
  logic [NBITS-1:0] shiftReg;
  logic             qualify;

  assign rxS       = syncQ[1];
  assign frameBit8 = shiftReg[NBITS-1];
  assign qualify   = strobes.frameDone && (!addrDetectEn || frameBit8);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      shiftReg <= '0;
    end else begin
      syncQ <= {syncQ[0], rxIn};
      if (strobes.shiftEn) shiftReg <= {rxS, shiftReg[NBITS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      rxBit8   <= 1'b0;
      rxFull   <= 1'b0;
      frameErr <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (rdStrobe) begin
        rxFull  <= 1'b0;
        overrun <= 1'b0;
      end
      if (qualify) begin
        if (rxFull && !rdStrobe) begin
          overrun <= 1'b1;
        end else begin
          rxData   <= shiftReg[DW-1:0];
          rxBit8   <= frameBit8;
          frameErr <= !rxS;
          rxFull   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx9_addr_rx.sv
module rx9_addr_rx
  import rx9_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int NBITS = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleEn,
  input  logic             rxIn,
  input  logic             addrDetectEn,
  input  logic             rdStrobe,
  output logic [NBITS-2:0] rxData,
  output logic             rxBit8,
  output logic             rxFull,
  output logic             frameErr,
  output logic             overrun
);
  rxStrobe_t ctl;
  logic      rxS;
  logic      frameBit8;
  logic      frameDone;

  assign frameDone = ctl.frameDone;

  rx9_ctrl #(.OVS(OVS), .NBITS(NBITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxS(rxS), .strobes(ctl)
  );

  rx9_datapath #(.NBITS(NBITS)) u_dp (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .addrDetectEn(addrDetectEn),
    .rdStrobe(rdStrobe), .strobes(ctl), .rxS(rxS), .frameBit8(frameBit8),
    .rxData(rxData), .rxBit8(rxBit8), .rxFull(rxFull),
    .frameErr(frameErr), .overrun(overrun)
  );
endmodule

// File: rtl/rx9_checker.sv
module rx9_checker #(
  parameter int NBITS = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             addrDetectEn,
  input logic             rdStrobe,
  input logic             frameDone,
  input logic             frameBit8,
  input logic [NBITS-2:0] rxData,
  input logic             rxBit8,
  input logic             rxFull,
  input logic             frameErr,
  input logic             overrun
);
  // R6: a read with no competing transfer empties the register
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe && !frameDone |=> !rxFull && !overrun);

  // R3: filtered data word leaves every output untouched
  p_drop_data_r3: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && addrDetectEn && !frameBit8 && !rdStrobe |=>
      $stable(rxData) && $stable(rxBit8) && $stable(rxFull) &&
      $stable(frameErr) && $stable(overrun));

  // R4: address word into an empty register is delivered
  p_load_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && addrDetectEn && frameBit8 && !rxFull |=> rxFull && rxBit8);

  // R5: with filtering off any word into an empty register is delivered
  p_load_any_r5: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && !addrDetectEn && !rxFull |=> rxFull && (rxBit8 == $past(frameBit8)));

  // R9: qualifying word into a full register keeps the held word
  p_overrun_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    frameDone && (!addrDetectEn || frameBit8) && rxFull && !rdStrobe |=>
      overrun && $stable(rxData) && $stable(rxBit8));

  // R2: the full flag only rises at a frame decision
  p_full_source_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $past(frameDone));
endmodule

bind rx9_addr_rx rx9_checker #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rstN(rstN), .addrDetectEn(addrDetectEn), .rdStrobe(rdStrobe),
  .frameDone(frameDone), .frameBit8(frameBit8), .rxData(rxData),
  .rxBit8(rxBit8), .rxFull(rxFull), .frameErr(frameErr), .overrun(overrun)
);

// File: tb/rx9_addr_rx_bench.sv
module rx9_addr_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 32; // 16 sample pulses, one every 2 clocks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleEn = 1'b0;
  logic       rxIn = 1'b1;
  logic       addrDetectEn = 1'b0;
  logic       rdStrobe = 1'b0;
  logic [7:0] rxData;
  logic       rxBit8, rxFull, frameErr, overrun;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] eData = '0;
  logic       eBit8 = 0, eFull = 0, eErr = 0, eOvr = 0;

  rx9_addr_rx u_rx9_addr_rx (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .rxIn(rxIn),
    .addrDetectEn(addrDetectEn), .rdStrobe(rdStrobe), .rxData(rxData),
    .rxBit8(rxBit8), .rxFull(rxFull), .frameErr(frameErr), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    sampleEn = ~sampleEn;
  end

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    check({req, " data"},    {1'b0, rxData}, {1'b0, eData});
    check({req, " bit8"},    {8'b0, rxBit8}, {8'b0, eBit8});
    check({req, " full"},    {8'b0, rxFull}, {8'b0, eFull});
    check({req, " ferr"},    {8'b0, frameErr}, {8'b0, eErr});
    check({req, " overrun"}, {8'b0, overrun}, {8'b0, eOvr});
  endtask

  function automatic void modelFrame(logic [8:0] w, logic stopOk, logic en);
    if (!en || w[8]) begin
      if (eFull) eOvr = 1'b1;
      else begin
        eData = w[7:0]; eBit8 = w[8]; eErr = !stopOk; eFull = 1'b1;
      end
    end
  endfunction

  task automatic holdLine(logic v, int clks);
    rxIn = v;
    repeat (clks) @(negedge clk);
  endtask

  // enAfter: value applied to addrDetectEn at the start of data bit 4
  task automatic sendFrame(logic [8:0] w, logic stopOk, logic enStart, logic enAfter);
    addrDetectEn = enStart;
    holdLine(1'b0, BIT_CLKS);
    for (int i = 0; i < 9; i++) begin
      if (i == 4) addrDetectEn = enAfter;
      holdLine(w[i], BIT_CLKS);
    end
    holdLine(stopOk, BIT_CLKS);
    holdLine(1'b1, 8);
    modelFrame(w, stopOk, enAfter);
  endtask

  task automatic doRead();
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    @(negedge clk);
    eFull = 1'b0; eOvr = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_0009));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    checkAll("R1 reset");

    // R5: filter off, data word delivered; R2 bit order
    sendFrame(9'h0A5, 1'b1, 1'b0, 1'b0);
    checkAll("R5/R2 data word, filter off");
    doRead();
    check("R6 full cleared by read", {8'b0, rxFull}, 9'd0);

    // R3: filter on, data word dropped
    sendFrame(9'h03C, 1'b1, 1'b1, 1'b1);
    checkAll("R3 data word dropped");

    // R4: filter on, address word delivered
    sendFrame(9'h1C3, 1'b1, 1'b1, 1'b1);
    checkAll("R4 address word accepted");

    // R9: second qualifying word while full
    sendFrame(9'h155, 1'b1, 1'b0, 1'b0);
    checkAll("R9 overrun keeps word");
    doRead();
    checkAll("R6 read clears full and overrun");

    // R8: framing error travels with word, dropped frame leaves it alone
    sendFrame(9'h181, 1'b0, 1'b1, 1'b1);
    checkAll("R8 framing error on word");
    doRead();
    sendFrame(9'h07E, 1'b1, 1'b1, 1'b1);
    checkAll("R8 dropped frame keeps frameErr");

    // R7: short glitch rejected
    holdLine(1'b0, 6);
    holdLine(1'b1, 3 * BIT_CLKS);
    checkAll("R7 false start ignored");

    // R10: enable changed mid-frame
    sendFrame(9'h011, 1'b1, 1'b0, 1'b1);
    checkAll("R10 enable set mid-frame drops");
    sendFrame(9'h022, 1'b1, 1'b1, 1'b0);
    checkAll("R10 enable cleared mid-frame accepts");
    doRead();

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [8:0] w;
      logic en, ok;
      w  = 9'($urandom);
      en = 1'($urandom);
      ok = ($urandom % 8) != 0;
      if ($urandom % 2) doRead();
      sendFrame(w, ok, en, en);
      checkAll(en ? (w[8] ? "R4 random" : "R3 random") : "R5 random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule